// File: doc/BRIEF.md
# USB Endpoint Receive Handshake Controller

This block runs the receive side of one USB device endpoint. It holds an 8-bit receive control register that software writes and reads. For every decoded bus event it decides whether the endpoint replies with ACK, NAK or STALL, or stays silent. Events are tokens (OUT, SETUP, other) and data packets, which carry a DATA0/DATA1 flag, a byte count and a CRC-good flag. After a good transfer the block flips its expected data toggle and parks the endpoint in NAK on its own, so software can drain the buffer before it re-arms. It also pulses a correct-transfer output.

Events arrive on a valid/ready stream. An event is taken on a cycle where `evt_valid` and `evt_ready` are both high. Handshake decisions leave on a second valid/ready stream. A decision stays on `hs_code` with `hs_valid` high until the consumer raises `hs_ready`. While a decision is held back, `evt_ready` is low, so pressure from the handshake consumer stalls the event producer. Mode pins (control, isochronous) and the reset inputs are plain levels. In isochronous mode no handshake is ever produced. In that mode the toggle bit works as a ping-pong buffer selector.

Top module: `usb_ep_rx_hs`

## Requirements
- R1: A high `bus_reset` or `force_reset` at a clock edge clears the whole register to 00h, as does `rst_n` low.
- R2: A software write stores `cfg_wr_data` into the register and `cfg_rd_data` shows the register at all times. The layout is bit 7 = status-out guard, bit 6 = expected toggle, bits 5:4 = receive status, bits 3:0 = endpoint address.
- R3: Receive status 00 (disabled) gives no reply. Status 01 answers every addressed data packet with STALL, status 10 answers it with NAK, and status 11 allows reception. Handshake codes are ACK = 00, NAK = 01, STALL = 10.
- R4: A data packet counts only when the OUT or SETUP token before it carried an address equal to bits 3:0. Otherwise the packet gets no reply and changes nothing.
- R5: With the guard bit set, an OUT data packet of one or more bytes gets STALL and changes nothing. A zero-length packet is handled as normal.
- R6: In non-isochronous valid state, a data packet whose DATA1 flag equals the expected toggle gets ACK. It also flips the toggle, sets the status to NAK and pulses `xfer_ok`.
- R7: A toggle mismatch in non-isochronous valid state gets ACK, but produces no `xfer_ok` pulse and no register change.
- R8: In control mode, an addressed SETUP token on an enabled endpoint clears the expected toggle to DATA0.
- R9: A data packet with `evt_crc_ok` low gets no handshake and changes no register field.
- R10: In isochronous mode with status valid, a DATA0 packet pulses `xfer_ok` and flips the toggle, with no handshake and no status change. DATA1 packets are ignored.
- R11: When a software write and a hardware update land on the same edge, the hardware values of the toggle and status fields win. The other fields take the software value.
- R12: A pending handshake holds `hs_valid` and `hs_code` steady and keeps `evt_ready` low until `hs_ready` is high.
- R13: `hs_valid` and `xfer_ok` rise in the cycle after the data event is taken, and `xfer_ok` lasts one cycle for each accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen on the line |
| force_reset | input | 1 | Reset forced by a control bit |
| ep_is_ctrl | input | 1 | Endpoint is a control endpoint |
| ep_is_iso | input | 1 | Endpoint is isochronous |
| cfg_wr_en | input | 1 | Software register write strobe |
| cfg_wr_data | input | 8 | Software write value |
| cfg_rd_data | output | 8 | Current register value |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Event can be taken |
| evt_kind | input | 2 | 0 OUT token, 1 SETUP token, 2 data packet, 3 other |
| evt_addr | input | 4 | Endpoint address of a token |
| evt_data1 | input | 1 | Data packet is DATA1 |
| evt_len | input | LEN_W | Data packet byte count |
| evt_crc_ok | input | 1 | Data packet had good CRC and no bit error |
| hs_valid | output | 1 | Handshake decision present |
| hs_ready | input | 1 | Handshake consumer takes the decision |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| xfer_ok | output | 1 | One-cycle correct-transfer pulse |

## Verification
The assertions check several behaviours on every cycle. A reset input empties the register by the next edge. A held handshake keeps its code. Every non-isochronous correct-transfer pulse comes with an ACK and a NAK status. Isochronous operation never raises a handshake and never moves the status without a write. The bench scenarios are needed for behaviours that depend on event history and exact data values: address filtering across token and data events, the guard that stalls nonzero-length packets, toggle mismatch discard, SETUP clearing the toggle, the ping-pong flips, and hardware winning over a simultaneous write.

// File: rtl/usb_ep_rx_pkg.sv
package usb_ep_rx_pkg;
  localparam int EP_ADDR_W = 4;
  localparam int REG_W     = EP_ADDR_W + 4;

  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } rx_stat_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_code_e;

  typedef enum logic [1:0] {
    EV_OUT   = 2'd0,
    EV_SETUP = 2'd1,
    EV_DATA  = 2'd2,
    EV_OTHER = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic                 guard;
    logic                 tog;
    rx_stat_e             stat;
    logic [EP_ADDR_W-1:0] addr;
  } rx_reg_t;
endpackage

// File: rtl/ep_rx_regfile.sv
module ep_rx_regfile
  import usb_ep_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    sw_we,
  input  rx_reg_t sw_wdata,
  input  logic    hw_tog_we,
  input  logic    hw_tog_val,
  input  logic    hw_stat_nak,
  output rx_reg_t q
);
  // Hardware field updates are applied after the software write, so they win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else begin
      if (sw_we)       q      <= sw_wdata;
      if (hw_tog_we)   q.tog  <= hw_tog_val;
      if (hw_stat_nak) q.stat <= ST_NAK;
    end
  end
endmodule

// File: rtl/ep_rx_decider.sv
module ep_rx_decider
  import usb_ep_rx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 accept,
  input  logic [1:0]           evt_kind,
  input  logic [EP_ADDR_W-1:0] evt_addr,
  input  logic                 evt_data1,
  input  logic [LEN_W-1:0]     evt_len,
  input  logic                 evt_crc_ok,
  input  logic                 ep_is_ctrl,
  input  logic                 ep_is_iso,
  input  rx_reg_t              cur,
  output logic                 dec_fire,
  output hs_code_e             dec_code,
  output logic                 dec_ok,
  output logic                 hw_tog_we,
  output logic                 hw_tog_val,
  output logic                 hw_stat_nak
);
  ev_kind_e kind;
  logic     addr_hit, enabled;
  logic     armed_q, armed_out_q;
  logic     arm_d, arm_out_d;
  logic     is_token, is_data;

  assign kind     = ev_kind_e'(evt_kind);
  assign addr_hit = (evt_addr == cur.addr);
  assign enabled  = (cur.stat != ST_DIS);
  assign is_token = accept && (kind != EV_DATA);
  assign is_data  = accept && (kind == EV_DATA);

  // Token tracking: which data packet, if any, belongs to this endpoint.
  always_comb begin
    arm_d     = 1'b0;
    arm_out_d = 1'b0;
    unique case (kind)
      EV_OUT:   begin arm_d = addr_hit; arm_out_d = addr_hit; end
      EV_SETUP: arm_d = addr_hit && ep_is_ctrl && !ep_is_iso;
      default:  arm_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      armed_out_q <= 1'b0;
    end else if (clr) begin
      armed_q     <= 1'b0;
      armed_out_q <= 1'b0;
    end else if (is_token) begin
      armed_q     <= arm_d;
      armed_out_q <= arm_out_d;
    end else if (is_data) begin
      armed_q     <= 1'b0;
      armed_out_q <= 1'b0;
    end
  end

  always_comb begin
    dec_fire    = 1'b0;
    dec_code    = HS_ACK;
    dec_ok      = 1'b0;
    hw_tog_we   = 1'b0;
    hw_tog_val  = 1'b0;
    hw_stat_nak = 1'b0;
    if (is_token && kind == EV_SETUP && arm_d && enabled) begin
      hw_tog_we  = 1'b1;
      hw_tog_val = 1'b0;
    end else if (is_data && armed_q && evt_crc_ok) begin
      if (ep_is_iso) begin
        if (cur.stat == ST_VALID && !evt_data1) begin
          dec_ok     = 1'b1;
          hw_tog_we  = 1'b1;
          hw_tog_val = !cur.tog;
        end
      end else begin
        unique case (cur.stat)
          ST_DIS:   dec_fire = 1'b0;
          ST_STALL: begin dec_fire = 1'b1; dec_code = HS_STALL; end
          ST_NAK:   begin dec_fire = 1'b1; dec_code = HS_NAK; end
          ST_VALID: begin
            dec_fire = 1'b1;
            if (armed_out_q && cur.guard && (evt_len != '0)) begin
              dec_code = HS_STALL;
            end else if (evt_data1 == cur.tog) begin
              dec_code    = HS_ACK;
              dec_ok      = 1'b1;
              hw_tog_we   = 1'b1;
              hw_tog_val  = !cur.tog;
              hw_stat_nak = 1'b1;
            end else begin
              dec_code = HS_ACK;
            end
          end
          default:  dec_fire = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ep_rx_hs_out.sv
module ep_rx_hs_out
  import usb_ep_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_fire,
  input  hs_code_e   dec_code,
  input  logic       dec_ok,
  input  logic       hs_ready,
  output logic       hs_valid,
  output logic [1:0] hs_code,
  output logic       xfer_ok,
  output logic       evt_ready
);
  assign evt_ready = !hs_valid || hs_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
      xfer_ok  <= 1'b0;
    end else begin
      xfer_ok <= dec_ok;
      if (dec_fire) begin
        hs_valid <= 1'b1;
        hs_code  <= dec_code;
      end else if (hs_ready) begin
        hs_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_ep_rx_hs.sv
module usb_ep_rx_hs
  import usb_ep_rx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_reset,
  input  logic                 force_reset,
  input  logic                 ep_is_ctrl,
  input  logic                 ep_is_iso,
  input  logic                 cfg_wr_en,
  input  logic [REG_W-1:0]     cfg_wr_data,
  output logic [REG_W-1:0]     cfg_rd_data,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [1:0]           evt_kind,
  input  logic [EP_ADDR_W-1:0] evt_addr,
  input  logic                 evt_data1,
  input  logic [LEN_W-1:0]     evt_len,
  input  logic                 evt_crc_ok,
  output logic                 hs_valid,
  input  logic                 hs_ready,
  output logic [1:0]           hs_code,
  output logic                 xfer_ok
);
  rx_reg_t  cur;
  logic     clr, accept;
  logic     dec_fire, dec_ok, hw_tog_we, hw_tog_val, hw_stat_nak;
  hs_code_e dec_code;

  assign clr         = bus_reset || force_reset;
  assign accept      = evt_valid && evt_ready;
  assign cfg_rd_data = cur;

  ep_rx_regfile u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .sw_we       (cfg_wr_en),
    .sw_wdata    (rx_reg_t'(cfg_wr_data)),
    .hw_tog_we   (hw_tog_we),
    .hw_tog_val  (hw_tog_val),
    .hw_stat_nak (hw_stat_nak),
    .q           (cur)
  );

  ep_rx_decider #(.LEN_W(LEN_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .accept      (accept),
    .evt_kind    (evt_kind),
    .evt_addr    (evt_addr),
    .evt_data1   (evt_data1),
    .evt_len     (evt_len),
    .evt_crc_ok  (evt_crc_ok),
    .ep_is_ctrl  (ep_is_ctrl),
    .ep_is_iso   (ep_is_iso),
    .cur         (cur),
    .dec_fire    (dec_fire),
    .dec_code    (dec_code),
    .dec_ok      (dec_ok),
    .hw_tog_we   (hw_tog_we),
    .hw_tog_val  (hw_tog_val),
    .hw_stat_nak (hw_stat_nak)
  );

  ep_rx_hs_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_fire  (dec_fire),
    .dec_code  (dec_code),
    .dec_ok    (dec_ok),
    .hs_ready  (hs_ready),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .xfer_ok   (xfer_ok),
    .evt_ready (evt_ready)
  );
endmodule

// File: rtl/ep_rx_hs_chk.sv
module ep_rx_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       force_reset,
  input logic       ep_is_iso,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_rd_data,
  input logic       evt_valid,
  input logic       evt_ready,
  input logic       hs_valid,
  input logic       hs_ready,
  input logic [1:0] hs_code,
  input logic       xfer_ok
);
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || force_reset) |=> (cfg_rd_data == 8'h00));

  p_hold_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ready) |=> (hs_valid && $stable(hs_code)));

  p_block_events_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ready) |-> !evt_ready);

  p_ok_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !ep_is_iso) |-> (hs_valid && hs_code == 2'b00 && cfg_rd_data[5:4] == 2'b10));

  p_iso_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_is_iso && $rose(hs_valid)) |-> !$past(ep_is_iso));

  p_iso_stat_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_is_iso && $past(ep_is_iso) && !$past(cfg_wr_en) && !$past(bus_reset || force_reset))
      |-> $stable(cfg_rd_data[5:4]));

  p_ok_follows_event_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_ok) |-> $past(evt_valid && evt_ready));
endmodule

bind usb_ep_rx_hs ep_rx_hs_chk u_chk (.*);

// File: tb/sim_usb_ep_rx_hs.sv
module sim_usb_ep_rx_hs;
  localparam int LEN_W = 11;
  localparam logic [1:0] K_OUT = 2'd0, K_SETUP = 2'd1, K_DATA = 2'd2;
  localparam logic [1:0] C_ACK = 2'b00, C_NAK = 2'b01, C_STALL = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 0, force_reset = 0, ep_is_ctrl = 0, ep_is_iso = 0;
  logic cfg_wr_en = 0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic evt_valid = 0, evt_data1 = 0, evt_crc_ok = 1, hs_ready = 1;
  logic evt_ready, hs_valid, xfer_ok;
  logic [1:0] evt_kind = '0, hs_code;
  logic [3:0] evt_addr = '0;
  logic [LEN_W-1:0] evt_len = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_ep_rx_hs #(.LEN_W(LEN_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_data = v;
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic ev(input logic [1:0] k, input logic [3:0] a, input logic d1,
                    input int len, input logic crc);
    @(negedge clk);
    evt_valid = 1; evt_kind = k; evt_addr = a; evt_data1 = d1;
    evt_len = LEN_W'(len); evt_crc_ok = crc;
    @(negedge clk);
    evt_valid = 0;
  endtask

  // OUT token then data; outputs sampled one cycle after the data event.
  task automatic pkt(input logic [1:0] tok, input logic [3:0] a, input logic d1,
                     input int len, input logic crc, input string req,
                     input bit exp_hs, input logic [1:0] exp_code,
                     input bit exp_ok, input logic [7:0] exp_reg);
    ev(tok, a, 1'b0, 0, 1'b1);
    ev(K_DATA, a, d1, len, crc);
    chk(hs_valid == exp_hs, req, hs_valid, exp_hs);
    if (exp_hs) chk(hs_code == exp_code, req, hs_code, exp_code);
    chk(xfer_ok == exp_ok, req, xfer_ok, exp_ok);
    chk(cfg_rd_data == exp_reg, req, cfg_rd_data, exp_reg);
  endtask

  task automatic t_reset_and_rw;
    chk(cfg_rd_data == 8'h00, "R1", cfg_rd_data, 8'h00);
    wr(8'h35);
    chk(cfg_rd_data == 8'h35, "R2", cfg_rd_data, 8'h35);
  endtask

  task automatic t_addr_filter;  // R4
    ev(K_OUT, 4'h6, 0, 0, 1);
    ev(K_DATA, 4'h5, 0, 4, 1);
    chk(!hs_valid, "R4", hs_valid, 0);
    chk(cfg_rd_data == 8'h35, "R4", cfg_rd_data, 8'h35);
  endtask

  task automatic t_good_and_status;
    pkt(K_OUT, 4'h5, 0, 4, 1, "R6", 1, C_ACK, 1, 8'h65);
    @(negedge clk);
    chk(!xfer_ok, "R13", xfer_ok, 0);
    pkt(K_OUT, 4'h5, 1, 4, 1, "R3", 1, C_NAK, 0, 8'h65);
    wr(8'h75);
    pkt(K_OUT, 4'h5, 0, 4, 1, "R7", 1, C_ACK, 0, 8'h75);
    pkt(K_OUT, 4'h5, 1, 4, 0, "R9", 0, C_ACK, 0, 8'h75);
    wr(8'h55);
    pkt(K_OUT, 4'h5, 1, 4, 1, "R3", 1, C_STALL, 0, 8'h55);
    wr(8'h05);
    pkt(K_OUT, 4'h5, 0, 4, 1, "R3", 0, C_ACK, 0, 8'h05);
  endtask

  task automatic t_guard;  // R5
    wr(8'hB5);
    pkt(K_OUT, 4'h5, 0, 3, 1, "R5", 1, C_STALL, 0, 8'hB5);
    pkt(K_OUT, 4'h5, 0, 0, 1, "R5", 1, C_ACK, 1, 8'hE5);
  endtask

  task automatic t_setup;  // R8
    ep_is_ctrl = 1;
    wr(8'h75);
    ev(K_SETUP, 4'h5, 0, 0, 1);
    chk(cfg_rd_data == 8'h35, "R8", cfg_rd_data, 8'h35);
    ev(K_DATA, 4'h5, 0, 8, 1);
    chk(hs_valid && hs_code == C_ACK, "R8", hs_code, C_ACK);
    chk(cfg_rd_data == 8'h65, "R8", cfg_rd_data, 8'h65);
    ep_is_ctrl = 0;
  endtask

  task automatic t_iso;  // R10
    ep_is_iso = 1;
    wr(8'h35);
    pkt(K_OUT, 4'h5, 0, 16, 1, "R10", 0, C_ACK, 1, 8'h75);
    pkt(K_OUT, 4'h5, 0, 16, 1, "R10", 0, C_ACK, 1, 8'h35);
    pkt(K_OUT, 4'h5, 1, 16, 1, "R10", 0, C_ACK, 0, 8'h35);
    ep_is_iso = 0;
  endtask

  task automatic t_backpressure;  // R12
    wr(8'h35);
    hs_ready = 0;
    pkt(K_OUT, 4'h5, 0, 2, 1, "R12", 1, C_ACK, 1, 8'h65);
    @(negedge clk);
    chk(hs_valid && hs_code == C_ACK, "R12", hs_valid, 1);
    chk(!evt_ready, "R12", evt_ready, 0);
    hs_ready = 1;
    @(negedge clk);
    chk(!hs_valid && evt_ready, "R12", hs_valid, 0);
  endtask

  task automatic t_priority;  // R11
    wr(8'h35);
    ev(K_OUT, 4'h5, 0, 0, 1);
    @(negedge clk);
    evt_valid = 1; evt_kind = K_DATA; evt_addr = 4'h5; evt_data1 = 0;
    evt_len = LEN_W'(1); evt_crc_ok = 1;
    cfg_wr_en = 1; cfg_wr_data = 8'h3A;
    @(negedge clk);
    evt_valid = 0; cfg_wr_en = 0;
    chk(cfg_rd_data == 8'h6A, "R11", cfg_rd_data, 8'h6A);
  endtask

  task automatic t_resets;  // R1
    wr(8'hF5);
    @(negedge clk); force_reset = 1;
    @(negedge clk); force_reset = 0;
    chk(cfg_rd_data == 8'h00, "R1", cfg_rd_data, 8'h00);
    wr(8'hF5);
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    chk(cfg_rd_data == 8'h00, "R1", cfg_rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_and_rw();
    t_addr_filter();
    t_good_and_status();
    t_guard();
    t_setup();
    t_iso();
    t_backpressure();
    t_priority();
    t_resets();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule